// File: doc/BRIEF.md
# Quad Output Combine and Fault Logic

This block decides, every clock, whether each of four low-side output channels is switched on. For each channel it merges a channel bit written over the serial interface with a parallel input pin. A serial-side mode bit picks whether the two are merged by AND or by OR. A program pin sets the polarity of the parallel inputs: when it is high the inputs are active high, and when it is low they are active low.

Protection circuitry outside the block delivers three digital flags per channel: overload or current limit, open load, and overtemperature. The block holds these in a sticky diagnosis register. The serial block reads it as a 2-bit code per channel and clears it with a one-cycle pulse when chip select rises at the end of a frame. While a channel's overtemperature flag is raised, its normal command is replaced by a low-duty restart pattern. That pattern comes from one prescaled counter that all channels share.

The channel commands are registered, so an input change shows at `chanOn` one clock later. An active-low asynchronous reset switches every channel off and empties the diagnosis register.

Top module: `quad_drive_combine`

## Requirements
- R1: While `rstN` is low, `chanOn` is 4'b0000, `diagCode` is all ones and `faultOk` is 4'b1111.
- R2: With `orMode` low and no overtemperature on channel i, `chanOn[i]` one clock later equals the channel's active parallel level AND `spiData[i]`.
- R3: With `orMode` high and no overtemperature on channel i, `chanOn[i]` one clock later equals the channel's active parallel level OR `spiData[i]`, so `spiData[i]`=1 turns the channel on even when its parallel input is inactive.
- R4: The active parallel level of channel i is `parIn[i]` when `progPol` is 1 and the inverse of `parIn[i]` when `progPol` is 0.
- R5: A high `overloadFlag[i]` on a clock edge sets channel i's code, `diagCode[2i+1:2i]`, to 2'b10 from the next clock, unless overtemperature has been recorded for that channel.
- R6: An open-load flag gives code 2'b01 and an overtemperature flag gives code 2'b00. A clean channel reads 2'b11. When several faults are recorded, overtemperature ranks above overload, and overload ranks above open load.
- R7: Recorded faults are sticky: they stay until a clock edge with `diagClear` high. A flag that is high on that same edge is kept.
- R8: While `overTempFlag[i]` is high, `chanOn[i]` one clock later follows the shared restart pattern. The pattern is on for the first PRESCALE clocks of every 16×PRESCALE clocks, counted from the first edge after reset.
- R9: `faultOk[i]` is the AND of the two bits of channel i's code, so 1 means no fault is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| progPol | input | 1 | Parallel input polarity: 1 active high, 0 active low |
| orMode | input | 1 | Combine select from the serial block: 1 OR, 0 AND |
| parIn | input | 4 | Parallel channel inputs |
| spiData | input | 4 | Channel bits latched by the serial block |
| overloadFlag | input | 4 | Per-channel overload or current-limit flag |
| openLoadFlag | input | 4 | Per-channel open-load flag |
| overTempFlag | input | 4 | Per-channel overtemperature flag |
| diagClear | input | 1 | One-cycle clear of the diagnosis register at end of frame |
| chanOn | output | 4 | Registered on command per channel |
| diagCode | output | 8 | 2-bit code per channel, channel i at bits [2i+1:2i] |
| faultOk | output | 4 | 1-bit status per channel, 1 means no fault |

## Verification
A wrong sticky bit shows at `diagCode` and `faultOk` on the very next clock, and it stays visible until the next clear. A wrong combine or polarity shows at `chanOn` one clock after the input pattern that exposes it. A shared counter that is out of phase shows only while some channel is overheated, at the first on-to-off or off-to-on edge of the restart pattern, within 16×PRESCALE clocks. The bench therefore compares every output against its model on every clock, through exhaustive input sweeps, long overtemperature stretches and random traffic.

// File: rtl/qdc_pkg.sv
package qdc_pkg;
  typedef struct packed {
    logic pwmOn;
    logic clearDiag;
  } qdcStrobe_t;
endpackage

// File: rtl/qdc_ctrl.sv
module qdc_ctrl
  import qdc_pkg::*;
#(
  parameter int PRESCALE   = 4,
  parameter int PWM_PERIOD = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       diagClear,
  output qdcStrobe_t strobe
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int PH_W  = $clog2(PWM_PERIOD);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PWM_PERIOD - 1);

  logic [PRE_W-1:0] preCnt;
  logic [PH_W-1:0]  phase;
  logic             tick;

  assign tick = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      phase  <= '0;
    end else begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
      if (tick) phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
    end
  end

  always_comb begin
    strobe.pwmOn     = (phase == '0);
    strobe.clearDiag = diagClear;
  end

  // R8
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && phase == PH_LAST) |=> (phase == '0));
  // R8
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(phase));
endmodule

// File: rtl/qdc_datapath.sv
module qdc_datapath
  import qdc_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  qdcStrobe_t          strobe,
  input  logic                progPol,
  input  logic                orMode,
  input  logic [NUM_CH-1:0]   parIn,
  input  logic [NUM_CH-1:0]   spiData,
  input  logic [NUM_CH-1:0]   overloadFlag,
  input  logic [NUM_CH-1:0]   openLoadFlag,
  input  logic [NUM_CH-1:0]   overTempFlag,
  output logic [NUM_CH-1:0]   chanOn,
  output logic [2*NUM_CH-1:0] diagCode,
  output logic [NUM_CH-1:0]   faultOk
);
  logic [NUM_CH-1:0] actLevel, cmd, nextOn;
  logic [NUM_CH-1:0] otSeen, olSeen, openSeen;

  assign actLevel = progPol ? parIn : ~parIn;
  assign cmd      = orMode ? (actLevel | spiData) : (actLevel & spiData);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign nextOn[i] = overTempFlag[i] ? strobe.pwmOn : cmd[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chanOn[i]   <= 1'b0;
        otSeen[i]   <= 1'b0;
        olSeen[i]   <= 1'b0;
        openSeen[i] <= 1'b0;
      end else begin
        chanOn[i]   <= nextOn[i];
        otSeen[i]   <= (otSeen[i]   & ~strobe.clearDiag) | overTempFlag[i];
        olSeen[i]   <= (olSeen[i]   & ~strobe.clearDiag) | overloadFlag[i];
        openSeen[i] <= (openSeen[i] & ~strobe.clearDiag) | openLoadFlag[i];
      end
    end

    always_comb begin
      if (otSeen[i])        diagCode[2*i+1:2*i] = 2'b00;
      else if (olSeen[i])   diagCode[2*i+1:2*i] = 2'b10;
      else if (openSeen[i]) diagCode[2*i+1:2*i] = 2'b01;
      else                  diagCode[2*i+1:2*i] = 2'b11;
    end
    assign faultOk[i] = diagCode[2*i+1] & diagCode[2*i];

    // R3
    or_turns_on_chk: assert property (@(posedge clk) disable iff (!rstN)
      (orMode && spiData[i] && !overTempFlag[i]) |=> chanOn[i]);
    // R2
    and_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!orMode && !spiData[i] && !overTempFlag[i]) |=> !chanOn[i]);
    // R6
    overtemp_code_chk: assert property (@(posedge clk) disable iff (!rstN)
      overTempFlag[i] |=> (diagCode[2*i+1:2*i] == 2'b00));
    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (diagCode[2*i+1:2*i] != 2'b11 && !strobe.clearDiag) |=> (diagCode[2*i+1:2*i] != 2'b11));
  end
endmodule

// File: rtl/quad_drive_combine.sv
module quad_drive_combine
  import qdc_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int PRESCALE   = 4,
  parameter int PWM_PERIOD = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                progPol,
  input  logic                orMode,
  input  logic [NUM_CH-1:0]   parIn,
  input  logic [NUM_CH-1:0]   spiData,
  input  logic [NUM_CH-1:0]   overloadFlag,
  input  logic [NUM_CH-1:0]   openLoadFlag,
  input  logic [NUM_CH-1:0]   overTempFlag,
  input  logic                diagClear,
  output logic [NUM_CH-1:0]   chanOn,
  output logic [2*NUM_CH-1:0] diagCode,
  output logic [NUM_CH-1:0]   faultOk
);
  qdcStrobe_t strobe;

  qdc_ctrl #(.PRESCALE(PRESCALE), .PWM_PERIOD(PWM_PERIOD)) u_ctrl (
    .clk(clk), .rstN(rstN), .diagClear(diagClear), .strobe(strobe)
  );

  qdc_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .progPol(progPol), .orMode(orMode), .parIn(parIn), .spiData(spiData),
    .overloadFlag(overloadFlag), .openLoadFlag(openLoadFlag),
    .overTempFlag(overTempFlag),
    .chanOn(chanOn), .diagCode(diagCode), .faultOk(faultOk)
  );
endmodule

// File: tb/sim_quad_drive_combine.sv
module sim_quad_drive_combine;
  localparam int CLK_PERIOD = 10;
  localparam int PRE = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       progPol = 1'b1, orMode = 1'b0, diagClear = 1'b0;
  logic [3:0] parIn = '0, spiData = '0, ovl = '0, opn = '0, ot = '0;
  logic [3:0] chanOn, faultOk;
  logic [7:0] diagCode;

  int checks = 0, errors = 0;
  string curReq = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_drive_combine #(.NUM_CH(4), .PRESCALE(PRE), .PWM_PERIOD(16)) u0 (
    .clk(clk), .rstN(rstN), .progPol(progPol), .orMode(orMode),
    .parIn(parIn), .spiData(spiData), .overloadFlag(ovl),
    .openLoadFlag(opn), .overTempFlag(ot), .diagClear(diagClear),
    .chanOn(chanOn), .diagCode(diagCode), .faultOk(faultOk)
  );

  // behavioural reference model
  bit mOt[4], mOl[4], mOpen[4];
  bit mOn[4];
  int mCnt = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin
        mOt[i] = 0; mOl[i] = 0; mOpen[i] = 0; mOn[i] = 0;
      end
      mCnt = 0;
    end else begin
      bit pwm;
      pwm = (((mCnt / PRE) % 16) == 0);
      for (int i = 0; i < 4; i++) begin
        bit act, cmd;
        act = progPol ? parIn[i] : !parIn[i];
        cmd = orMode ? (act || spiData[i]) : (act && spiData[i]);
        mOn[i] = ot[i] ? pwm : cmd;
        if (diagClear) begin
          mOt[i] = ot[i]; mOl[i] = ovl[i]; mOpen[i] = opn[i];
        end else begin
          mOt[i] = mOt[i] | ot[i]; mOl[i] = mOl[i] | ovl[i]; mOpen[i] = mOpen[i] | opn[i];
        end
      end
      mCnt++;
    end
  end

  function automatic logic [1:0] expCode(int i);
    if (mOt[i]) return 2'b00;
    if (mOl[i]) return 2'b10;
    if (mOpen[i]) return 2'b01;
    return 2'b11;
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] eOn, eOk;
      logic [7:0] eCode;
      for (int i = 0; i < 4; i++) begin
        eOn[i] = mOn[i];
        eCode[2*i +: 2] = expCode(i);
        eOk[i] = &expCode(i);
      end
      checks++;
      if (chanOn !== eOn) begin
        errors++;
        $display("FAIL %s chanOn actual %b expected %b at %0t", curReq, chanOn, eOn, $time);
      end
      checks++;
      if (diagCode !== eCode) begin
        errors++;
        $display("FAIL %s diagCode actual %b expected %b at %0t", curReq, diagCode, eCode, $time);
      end
      checks++;
      if (faultOk !== eOk) begin
        errors++;
        $display("FAIL R9 faultOk actual %b expected %b at %0t", faultOk, eOk, $time);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R1..all actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs while held in reset
    curReq = "R1";
    step(3);
    checks++;
    if (chanOn !== 4'b0000 || diagCode !== 8'hFF || faultOk !== 4'hF) begin
      errors++;
      $display("FAIL R1 reset actual %b/%h/%b expected 0000/ff/1111", chanOn, diagCode, faultOk);
    end
    rstN = 1'b1;
    step(2);

    // R2 and R4: AND mode, both polarities, all patterns
    curReq = "R2/R4";
    orMode = 1'b0;
    for (int p = 1; p >= 0; p--) begin
      progPol = p[0];
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          parIn = a[3:0]; spiData = b[3:0]; step();
        end
    end

    // R3 and R4: OR mode, serial bit forces on with parallel inactive
    curReq = "R3/R4";
    orMode = 1'b1;
    for (int p = 0; p < 2; p++) begin
      progPol = p[0];
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          parIn = a[3:0]; spiData = b[3:0]; step();
        end
    end
    progPol = 1'b1; parIn = 4'b0000; spiData = 4'b1111; step();
    checks++;
    if (chanOn !== 4'b1111) begin
      errors++;
      $display("FAIL R3 chanOn actual %b expected 1111", chanOn);
    end

    // R5: overload pulse, sticky
    curReq = "R5/R7";
    ovl = 4'b0010; step(); ovl = 4'b0000; step(5);
    checks++;
    if (diagCode[3:2] !== 2'b10) begin
      errors++;
      $display("FAIL R5 code ch1 actual %b expected 10", diagCode[3:2]);
    end

    // R6: open load and priority
    curReq = "R6";
    opn = 4'b0011; step(); opn = 4'b0000; step(2);
    checks++;
    if (diagCode[1:0] !== 2'b01 || diagCode[3:2] !== 2'b10) begin
      errors++;
      $display("FAIL R6 codes actual %b expected 1001", diagCode[3:0]);
    end
    ot = 4'b0001; step(); ot = 4'b0000; step(2);

    // R7: clear, with a flag present on the clear edge
    curReq = "R7";
    diagClear = 1'b1; ovl = 4'b1000; step();
    diagClear = 1'b0; ovl = 4'b0000; step(3);
    checks++;
    if (diagCode !== 8'b10_11_11_11) begin
      errors++;
      $display("FAIL R7 diagCode actual %b expected 10111111", diagCode);
    end
    diagClear = 1'b1; step(); diagClear = 1'b0; step(2);

    // R8: long overtemperature stretch, mixed commands
    curReq = "R8";
    orMode = 1'b1; spiData = 4'b0101; parIn = 4'b0000;
    ot = 4'b0011; step(200);
    ot = 4'b1111; step(150);
    ot = 4'b0000; step(5);

    // mid-run reset restarts the shared pattern
    curReq = "R1";
    rstN = 1'b0; step(2); rstN = 1'b1; step();
    curReq = "R8";
    ot = 4'b0100; spiData = 4'b1111; step(140);
    ot = 4'b0000;

    // random mix
    curReq = "R2..R9 random";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      parIn = r[3:0]; spiData = r[7:4];
      ovl = r[11:8] & {4{r[24]}};
      opn = r[15:12] & {4{r[25]}};
      ot  = r[19:16] & {4{r[26] & r[27]}};
      orMode = r[20]; progPol = r[21];
      diagClear = r[22] & r[23];
      step();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule